// File: doc/BRIEF.md
# Transmit Start Gate with Interframe Gap and Deferral Timing

This block decides the cycle in which a queued frame may go onto a 10 Mbit/s half-duplex medium. It runs on the bit clock, so one cycle is one bit time. It measures the quiet time since the medium was last busy, either from sensed carrier or from the station's own transmission. A host holds a request level high. The block answers with a one-cycle start grant once the full 96-bit gap has passed and carrier allows it.

The gap has two parts. If this station sent last, and the request is seen while fewer than 64 bit times of gap have passed, the block commits to that request. It then ignores carrier and grants at the end of the 96-bit gap. In every other case sensed carrier is honoured. Carrier restarts the gap, and the start waits for a fresh full gap after carrier drops.

A deferral counter measures how long a request has waited. When it saturates, the request is abandoned and a flag is raised until the host withdraws the request. The host reports the end of its own transmission with a one-cycle pulse. There is no data stream on this block: every pin is a plain control or status level.

Top module: `txgap_gate`

## Requirements
- R1: After reset all three outputs are low and the gap count is zero, so a request raised just after reset is granted on the 97th clock edge.
- R2: When the gap count has already reached 96 and carrier is low, a newly raised request is granted on the next clock edge.
- R3: A request first sampled when this station sent last and fewer than 64 gap cycles have elapsed is committed. Carrier is then ignored, `deferring` stays low, and the grant comes on the 97th edge after the reference edge.
- R4: A request that is not committed honours carrier. Each edge that samples carrier high sets the gap to zero, and the grant comes on the 97th edge after the last such edge.
- R5: Carrier sampled high on the edge where the gap is full blocks the grant and restarts the gap.
- R6: Carrier sampled while no request is committed cancels the "sent last" status, so a later early request is not committed.
- R7: `deferring` goes high one edge after an edge that samples a pending, ungranted request together with honoured carrier.
- R8: A request that has waited 32768 edges without a grant raises `excess_defer` on that edge, and it is never granted afterwards.
- R9: Dropping the request clears `excess_defer` on the next edge and restarts the deferral count from zero.
- R10: `start_ok` is high for exactly one cycle, and only once per request, even after `own_tx_end` while the request stays high.
- R11: The edge that samples `own_tx_end` high sets the gap to zero and ends the transmit phase, and that edge is the gap reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one cycle per bit time |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_sense | input | 1 | Carrier present on the medium |
| tx_pending | input | 1 | Host holds a frame ready to send |
| own_tx_end | input | 1 | One-cycle pulse when this station's transmission ends |
| start_ok | output | 1 | One-cycle grant to begin the preamble |
| deferring | output | 1 | Pending request held back by carrier |
| excess_defer | output | 1 | Request abandoned after deferral timeout |

## Verification
Every output is taken straight from a register. `start_ok`, `deferring` and `excess_defer` therefore change one clock edge after the inputs that cause them.

The bench counts edges from a reference edge: either the edge that samples the end pulse, or the last edge that samples carrier high. It drives inputs on the falling edge and reads outputs on the following falling edge. That way the edge count k matches the gap arithmetic of the requirements exactly, including the 97-edge grant, the 64-cycle split and the 32768-edge timeout.

// File: rtl/txg_pkg.sv
package txg_pkg;

  // Snapshot of the gap timer seen by the start controller
  typedef struct packed {
    logic full;      // gap count has reached the full gap
    logic early;     // gap count is below the split point
    logic own_last;  // this station was the last one on the medium
  } gap_view_t;

endpackage

// File: rtl/txg_gap_timer.sv
module txg_gap_timer
  import txg_pkg::*;
#(
  parameter int GAP_FULL  = 96,
  parameter int GAP_SPLIT = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      own_tx_end,
  input  logic      in_tx,
  input  logic      crs_block,
  input  logic      launch,
  output gap_view_t view
);
  localparam int GW = $clog2(GAP_FULL + 1);
  localparam logic [GW-1:0] FULL_V  = GW'(GAP_FULL);
  localparam logic [GW-1:0] SPLIT_V = GW'(GAP_SPLIT);

  logic [GW-1:0] gap_q;
  logic          own_last_q;

  // Gap count: cleared by any medium activity, saturates at the full gap
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (own_tx_end || in_tx || launch || crs_block) begin
      gap_q <= '0;
    end else if (gap_q != FULL_V) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // Last-sender status: set by our own end, cleared by foreign carrier
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_last_q <= 1'b0;
    end else if (own_tx_end) begin
      own_last_q <= 1'b1;
    end else if (crs_block) begin
      own_last_q <= 1'b0;
    end
  end

  always_comb begin
    view.full     = (gap_q == FULL_V);
    view.early    = (gap_q < SPLIT_V);
    view.own_last = own_last_q;
  end
endmodule

// File: rtl/txg_defer_timer.sv
module txg_defer_timer #(
  parameter int DEFER_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_pending,
  input  logic waiting,
  input  logic launch,
  output logic expired
);
  localparam logic [DEFER_W-1:0] CNT_MAX = '1;

  logic [DEFER_W-1:0] cnt_q;
  logic               exp_q;

  // Waiting-time count, saturating at all ones
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!tx_pending || launch) begin
      cnt_q <= '0;
    end else if (waiting && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Timeout flag, held until the request is withdrawn
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q <= 1'b0;
    end else if (!tx_pending) begin
      exp_q <= 1'b0;
    end else if (waiting && cnt_q == CNT_MAX) begin
      exp_q <= 1'b1;
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/txg_start_ctrl.sv
module txg_start_ctrl
  import txg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_pending,
  input  logic      carrier_sense,
  input  logic      own_tx_end,
  input  gap_view_t view,
  input  logic      expired,
  output logic      waiting,
  output logic      launch,
  output logic      crs_block,
  output logic      in_tx,
  output logic      start_ok,
  output logic      deferring
);
  logic served_q, tx_q, commit_q, start_q, defer_q;
  logic ignore_crs;

  always_comb begin
    waiting    = tx_pending && !served_q && !tx_q && !expired;
    // Commit happens on the first waiting edge inside the early part of our own gap
    ignore_crs = commit_q || (waiting && view.own_last && view.early);
    crs_block  = carrier_sense && !ignore_crs;
    launch     = waiting && view.full && !crs_block;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      served_q <= 1'b0;
      tx_q     <= 1'b0;
      commit_q <= 1'b0;
      start_q  <= 1'b0;
      defer_q  <= 1'b0;
    end else begin
      if (!tx_pending)  served_q <= 1'b0;
      else if (launch)  served_q <= 1'b1;

      if (own_tx_end)   tx_q <= 1'b0;
      else if (launch)  tx_q <= 1'b1;

      if (!waiting || launch) commit_q <= 1'b0;
      else if (ignore_crs)    commit_q <= 1'b1;

      start_q <= launch;
      defer_q <= waiting && crs_block;
    end
  end

  assign in_tx     = tx_q;
  assign start_ok  = start_q;
  assign deferring = defer_q;
endmodule

// File: rtl/txgap_gate.sv
module txgap_gate
  import txg_pkg::*;
#(
  parameter int GAP_FULL  = 96,
  parameter int GAP_SPLIT = 64,
  parameter int DEFER_W   = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_sense,
  input  logic tx_pending,
  input  logic own_tx_end,
  output logic start_ok,
  output logic deferring,
  output logic excess_defer
);
  gap_view_t view;
  logic waiting, launch, crs_block, in_tx, expired;

  txg_gap_timer #(.GAP_FULL(GAP_FULL), .GAP_SPLIT(GAP_SPLIT)) u_gap (
    .clk(clk), .rst_n(rst_n), .own_tx_end(own_tx_end), .in_tx(in_tx),
    .crs_block(crs_block), .launch(launch), .view(view)
  );

  txg_defer_timer #(.DEFER_W(DEFER_W)) u_defer (
    .clk(clk), .rst_n(rst_n), .tx_pending(tx_pending), .waiting(waiting),
    .launch(launch), .expired(expired)
  );

  txg_start_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_pending(tx_pending),
    .carrier_sense(carrier_sense), .own_tx_end(own_tx_end), .view(view),
    .expired(expired), .waiting(waiting), .launch(launch),
    .crs_block(crs_block), .in_tx(in_tx), .start_ok(start_ok),
    .deferring(deferring)
  );

  assign excess_defer = expired;
endmodule

// File: rtl/txgap_gate_chk.sv
module txgap_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_pending,
  input logic start_ok,
  input logic deferring,
  input logic excess_defer
);
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !start_ok);

  // R10
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> $past(tx_pending));

  // R8
  no_grant_on_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && excess_defer));

  // R7
  defer_excl_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && deferring));

  // R9
  drop_clears_excess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pending |=> !excess_defer);

  // R8
  excess_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(excess_defer) |-> $past(tx_pending));
endmodule

bind txgap_gate txgap_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_pending(tx_pending), .start_ok(start_ok),
  .deferring(deferring), .excess_defer(excess_defer)
);

// File: tb/tb_txgap_gate.sv
module tb_txgap_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crs = 1'b0, pend = 1'b0, own = 1'b0;
  logic start_ok, deferring, excess_defer;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  txgap_gate dut (
    .clk(clk), .rst_n(rst_n), .carrier_sense(crs), .tx_pending(pend),
    .own_tx_end(own), .start_ok(start_ok), .deferring(deferring),
    .excess_defer(excess_defer)
  );

  // columns: own reference, request edge, carrier from, carrier to (exclusive),
  // expected grant edge, expected deferring seen
  localparam int NV = 11;
  localparam int VT [NV][6] = '{
    '{1, 10,   0,   0,  97, 0},
    '{1, 10,  20, 200,  97, 0},
    '{1, 80,  85, 120, 216, 1},
    '{0, 10,  30,  40, 136, 1},
    '{0, 100,  0,   0, 100, 0},
    '{1, 100,  0,   0, 100, 0},
    '{1, 64,  70,  90,  97, 0},
    '{1, 65,  70,  90, 186, 1},
    '{1, 100, 100, 110, 206, 1},
    '{1, 5,    5,  60,  97, 0},
    '{1, 30,  10,  20, 116, 0}
  };
  string vtag [NV] = '{"R11", "R3", "R4/R7", "R4/R7", "R2", "R2", "R3",
                       "R4", "R5", "R3", "R6"};

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    pend = 1'b0; crs = 1'b0; own = 1'b1;
    step();
    own = 1'b0;
    repeat (100) step();
  endtask

  task automatic wait_excess(output int n);
    n = -1;
    for (int k = 1; k <= 40000 && n < 0; k++) begin
      step();
      if (excess_defer) n = k;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, n, pulses;
    bit dseen;
    // R1: reset state
    repeat (3) step();
    chk(start_ok == 0 && deferring == 0 && excess_defer == 0, "R1 outputs", 
        {start_ok, deferring, excess_defer}, 0);
    rst_n = 1'b1; pend = 1'b1;
    lat = -1;
    for (int k = 1; k <= 200 && lat < 0; k++) begin
      step();
      if (start_ok) lat = k;
    end
    chk(lat == 97, "R1 empty gap after reset", lat, 97);

    // vector table
    for (int v = 0; v < NV; v++) begin
      idle();
      if (VT[v][0] != 0) begin own = 1'b1; step(); own = 1'b0; end
      else begin crs = 1'b1; step(); crs = 1'b0; end
      lat = -1; dseen = 1'b0;
      for (int k = 1; k <= 400 && lat < 0; k++) begin
        pend = (k >= VT[v][1]);
        crs  = (k >= VT[v][2]) && (k < VT[v][3]);
        step();
        if (deferring) dseen = 1'b1;
        if (start_ok) lat = k;
      end
      pend = 1'b0; crs = 1'b0;
      chk(lat == VT[v][4], {vtag[v], " grant edge"}, lat, VT[v][4]);
      chk(int'(dseen) == VT[v][5], {vtag[v], " deferring"}, int'(dseen), VT[v][5]);
    end

    // R10: one grant per request
    idle();
    pend = 1'b1; step();
    chk(start_ok == 1, "R10 first grant", start_ok, 1);
    pulses = 0;
    repeat (20) begin step(); if (start_ok) pulses++; end
    own = 1'b1; step(); own = 1'b0;
    repeat (150) begin step(); if (start_ok) pulses++; end
    chk(pulses == 0, "R10 no repeat grant", pulses, 0);
    pend = 1'b0; step();
    pend = 1'b1; step();
    chk(start_ok == 1, "R10 new request granted", start_ok, 1);
    pend = 1'b0;

    // R8: excessive deferral
    idle();
    crs = 1'b1; pend = 1'b1;
    repeat (10) step();
    chk(deferring == 1, "R7 deferring under carrier", deferring, 1);
    wait_excess(n);
    chk(n == 32758, "R8 timeout edge", n + 10, 32768);
    step();
    chk(deferring == 0, "R8 deferring drops after abort", deferring, 0);
    crs = 1'b0; pulses = 0;
    repeat (200) begin step(); if (start_ok) pulses++; end
    chk(pulses == 0, "R8 abandoned request not granted", pulses, 0);
    pend = 1'b0; step();
    chk(excess_defer == 0, "R9 flag cleared", excess_defer, 0);
    pend = 1'b1; step();
    chk(start_ok == 1, "R9 fresh request granted", start_ok, 1);
    pend = 1'b0;

    // R9: withdrawal restarts the count
    idle();
    crs = 1'b1; pend = 1'b1;
    repeat (20000) step();
    chk(excess_defer == 0, "R9 no timeout yet", excess_defer, 0);
    pend = 1'b0; step();
    pend = 1'b1;
    wait_excess(n);
    chk(n == 32768, "R9 count restarted", n, 32768);
    pend = 1'b0; crs = 1'b0; step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule